// File: doc/BRIEF.md
# JTAG Instruction Trigger Detector

This block is a passive observer on a JTAG bus. It samples TCK, TMS and TDI with a fast system clock and raises a one-cycle trigger when a chosen instruction code is loaded. It lets a debug or capture unit react to one instruction out of a busy stream of bus traffic.

The block does not follow the TAP state machine. It treats TMS as an active-low select and TDI as serial data. A frame is armed after at least `ARM_HIGHS` rising TCK edges in a row with TMS high. The frame opens on the first rising edge where TMS is low. It holds `CODE_W` TDI bits, packed least significant bit first.

For a normal instruction load, this framing has two effects:
- The two TDI bits sampled before shifting starts land in the two low bits.
- The instruction's last bit is cut off, because TMS is already high when that bit is shifted.

The completed word goes to the `frame_code` output. It is also compared with the `trig_code` input.

Top module: `jtrig_monitor`

## Requirements
- R1: After reset, `trig_pulse` is 0 and `frame_code` is 0.
- R2: A frame begins only on a rising TCK edge with TMS low that directly follows at least 2 consecutive rising TCK edges with TMS high. A single TMS-high edge before a run of low edges, as on the data-register path, starts no frame.
- R3: A frame collects exactly 7 TDI values, one per rising TCK edge while TMS stays low. The first bit sampled becomes bit 0 of the word.
- R4: For a 6-bit instruction `ir` loaded through Capture-IR and Shift-IR, let p0 and p1 be the TDI values at the first two low-TMS edges. The word is then {ir[4:0], p1, p0}. With p0 = p1 = 0 the results are:
  - 110111 gives 0x5C
  - 110001 gives 0x44
  - 110011 gives 0x4C
  - 110100 gives 0x50
  - 010010 gives 0x48
  - 010101 gives 0x54
  - 010000 gives 0x40
- R5: If TMS is high on a rising TCK edge before the 7th bit is collected, the partial frame is dropped. No pulse is raised and `frame_code` keeps its value.
- R6: `trig_pulse` is high for exactly one system clock cycle when a completed frame equals `trig_code`. It stays low when they differ.
- R7: `frame_code` takes the value of every completed frame, whether it matches `trig_code` or not. It changes at no other time.
- R8: After a frame completes, further TMS-low edges are ignored until the detector is re-armed by R2.
- R9: `trig_pulse` rises on the 4th system clock edge after the TCK rise that carries the 7th bit. This holds when each TCK level lasts at least 3 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than TCK |
| rst | input | 1 | Synchronous active-high reset |
| tck | input | 1 | Observed JTAG clock, asynchronous |
| tms | input | 1 | Observed JTAG mode select, asynchronous |
| tdi | input | 1 | Observed JTAG data in, asynchronous |
| trig_code | input | 7 | Word to trigger on |
| trig_pulse | output | 1 | One-cycle match pulse |
| frame_code | output | 7 | Last completed frame |

## Verification
Seven known instruction loads with quiet lead-in bits check the bit order and the loss of the top bit against fixed values. Loads with a set lead-in bit show whether the pre-shift samples reach the low bits. Three directed negative patterns each separate a correct detector from a specific fault:
- a data-register scan with only one TMS-high edge catches a detector that arms too easily;
- a frame cut short by TMS, then followed by more low bits, catches a detector that does not drop partial frames;
- a 14-bit low run catches a detector that starts a second frame without re-arming.

Random instruction loads with varied arming lengths and trigger codes, half chosen to match, check both the pulse decision and the pulse timing.

// File: rtl/jtrig_pkg.sv
package jtrig_pkg;
  typedef enum logic [0:0] {
    FR_HUNT  = 1'b0,
    FR_SHIFT = 1'b1
  } frame_st_e;
endpackage

// File: rtl/jtrig_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
module jtrig_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/jtrig_edge.sv
// Rising-edge detector for the synchronized TCK.
module jtrig_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);
  logic sig_d;

  always_ff @(posedge clk) begin
    if (rst) sig_d <= 1'b0;
    else     sig_d <= sig;
  end

  assign rise = sig & ~sig_d;
endmodule

// File: rtl/jtrig_framer.sv
// Arms on consecutive TMS-high edges, then collects W TDI bits LSB first.
module jtrig_framer
  import jtrig_pkg::*;
#(
  parameter int W         = 7,
  parameter int ARM_HIGHS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise,
  input  logic         tms,
  input  logic         tdi,
  output logic         done,
  output logic [W-1:0] word
);
  localparam int CNT_W = $clog2(W + 1);
  localparam int HI_W  = $clog2(ARM_HIGHS + 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(W);
  localparam logic [HI_W-1:0]  ARM_MAX = HI_W'(ARM_HIGHS);

  frame_st_e        st;
  logic [HI_W-1:0]  hi_cnt;
  logic [CNT_W-1:0] bit_cnt;
  logic [W-1:0]     sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FR_HUNT;
      hi_cnt  <= '0;
      bit_cnt <= '0;
      sreg    <= '0;
      done    <= 1'b0;
      word    <= '0;
    end else begin
      done <= 1'b0;
      if (rise) begin
        if (tms) begin
          // select released: count toward arming, drop any partial frame
          if (hi_cnt != ARM_MAX) hi_cnt <= hi_cnt + 1'b1;
          st      <= FR_HUNT;
          bit_cnt <= '0;
        end else begin
          hi_cnt <= '0;
          if (st == FR_SHIFT) begin
            if (bit_cnt == LAST) begin
              done    <= 1'b1;
              word    <= {tdi, sreg[W-1:1]};
              st      <= FR_HUNT;
              bit_cnt <= '0;
            end else begin
              sreg    <= {tdi, sreg[W-1:1]};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end else if (hi_cnt == ARM_MAX) begin
            st      <= FR_SHIFT;
            sreg    <= {tdi, sreg[W-1:1]};
            bit_cnt <= CNT_W'(1);
          end
        end
      end
    end
  end

  // R3: bit counter never reaches the frame length
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    bit_cnt < CNT_LIM);

  // R3: completion only from a low-TMS edge while shifting
  assert_done_src_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(st == FR_SHIFT && rise && !tms));

  // R5: TMS high during a frame aborts it without completion
  assert_abort_R5: assert property (@(posedge clk) disable iff (rst)
    (rise && tms && st == FR_SHIFT) |=> (st == FR_HUNT && !done));

  // R2: a low edge without enough preceding highs does not open a frame
  assert_no_arm_R2: assert property (@(posedge clk) disable iff (rst)
    (rise && !tms && st == FR_HUNT && hi_cnt != ARM_MAX) |=> (st == FR_HUNT));
endmodule

// File: rtl/jtrig_monitor.sv
// Top: synchronize bus pins, frame instruction bits, compare and pulse.
module jtrig_monitor #(
  parameter int CODE_W      = 7,
  parameter int ARM_HIGHS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  input  logic [CODE_W-1:0] trig_code,
  output logic              trig_pulse,
  output logic [CODE_W-1:0] frame_code
);
  localparam int PINS = 3;

  logic [PINS-1:0]   pins_s;
  logic              tck_s, tms_s, tdi_s;
  logic              tck_rise;
  logic              f_done;
  logic [CODE_W-1:0] f_word;

  jtrig_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({tck, tms, tdi}),
    .q   (pins_s)
  );

  assign {tck_s, tms_s, tdi_s} = pins_s;

  jtrig_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .sig  (tck_s),
    .rise (tck_rise)
  );

  jtrig_framer #(.W(CODE_W), .ARM_HIGHS(ARM_HIGHS)) u_framer (
    .clk  (clk),
    .rst  (rst),
    .rise (tck_rise),
    .tms  (tms_s),
    .tdi  (tdi_s),
    .done (f_done),
    .word (f_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_pulse <= 1'b0;
      frame_code <= '0;
    end else begin
      trig_pulse <= f_done && (f_word == trig_code);
      if (f_done) frame_code <= f_word;
    end
  end

  // R6: pulse lasts one cycle
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |=> !trig_pulse);

  // R6: a pulse always reports a frame equal to the code in force
  assert_pulse_match_R6: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |-> (frame_code == $past(trig_code)));

  // R7: captured code moves only on completed frames
  assert_code_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !f_done |=> $stable(frame_code));
endmodule

// File: tb/test_jtrig_monitor.sv
`timescale 1ns/1ps
module test_jtrig_monitor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tck = 1'b0;
  logic       tms = 1'b0;
  logic       tdi = 1'b0;
  logic [6:0] trig_code = 7'h00;
  logic       trig_pulse;
  logic [6:0] frame_code;

  int checks = 0, fails = 0;
  int cyc = 0, pulses = 0, wide = 0, badlat = 0, last_rise = 0;
  logic prev_p = 1'b0;

  always #5 clk = ~clk;

  jtrig_monitor i_jtrig_monitor (
    .clk(clk), .rst(rst), .tck(tck), .tms(tms), .tdi(tdi),
    .trig_code(trig_code), .trig_pulse(trig_pulse), .frame_code(frame_code)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && trig_pulse) begin
      pulses = pulses + 1;
      if (prev_p) wide = wide + 1;
      if (cyc - last_rise != 4) badlat = badlat + 1;
    end
    prev_p = trig_pulse;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_frame(input logic [5:0] ir, input logic p0, input logic p1);
    return {ir[4:0], p1, p0};
  endfunction

  task automatic tcyc(input logic m, input logic d);
    @(negedge clk);
    tms = m; tdi = d;
    repeat (5) @(negedge clk);
    tck = 1'b1; last_rise = cyc;
    repeat (5) @(negedge clk);
    tck = 1'b0;
  endtask

  task automatic scan_ir(input logic [5:0] ir, input logic p0, input logic p1, input int highs);
    tcyc(1'b0, 1'b0);
    for (int i = 0; i < highs; i++) tcyc(1'b1, 1'($urandom));
    tcyc(1'b0, p0);
    tcyc(1'b0, p1);
    for (int i = 0; i < 5; i++) tcyc(1'b0, ir[i]);
    tcyc(1'b1, ir[5]);
    tcyc(1'b1, 1'b0);
    tcyc(1'b0, 1'b0);
    repeat (6) @(negedge clk);
  endtask

  task automatic low_bits(input logic [6:0] v, input int n);
    for (int i = 0; i < n; i++) tcyc(1'b0, v[i]);
  endtask

  task automatic directed(input logic [5:0] ir, input logic [6:0] lit);
    int p0;
    trig_code = lit;
    p0 = pulses;
    scan_ir(ir, 1'b0, 1'b0, 2);
    chk("R4 table value", 32'(frame_code), 32'(lit));
    chk("R4 model value", 32'(exp_frame(ir, 1'b0, 1'b0)), 32'(lit));
    chk("R6 match pulse", 32'(pulses - p0), 32'd1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int pb;
    logic [6:0] fc;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pulse", 32'(trig_pulse), 32'd0);
    chk("R1 reset code", 32'(frame_code), 32'd0);

    // R4 / R6: known instruction loads
    directed(6'b110111, 7'h5C);
    directed(6'b110001, 7'h44);
    directed(6'b110011, 7'h4C);
    directed(6'b110100, 7'h50);
    directed(6'b010010, 7'h48);
    directed(6'b010101, 7'h54);
    directed(6'b010000, 7'h40);

    // R6 / R7: mismatch still captures, no pulse
    trig_code = 7'h44; pb = pulses;
    scan_ir(6'b110111, 1'b0, 1'b0, 2);
    chk("R7 capture on mismatch", 32'(frame_code), 32'h5C);
    chk("R6 no pulse on mismatch", 32'(pulses - pb), 32'd0);

    // R3 / R4: lead-in bit lands at bit 0
    trig_code = 7'h41; pb = pulses;
    scan_ir(6'b110000, 1'b1, 1'b0, 2);
    chk("R3 lead-in bit order", 32'(frame_code), 32'h41);
    chk("R3 lead-in pulse", 32'(pulses - pb), 32'd1);

    // R2: three highs still arm
    trig_code = 7'h54; pb = pulses;
    scan_ir(6'b010101, 1'b0, 1'b0, 3);
    chk("R2 long arm code", 32'(frame_code), 32'h54);
    chk("R2 long arm pulse", 32'(pulses - pb), 32'd1);

    // R2: data-register path (one high) opens no frame
    fc = frame_code; trig_code = 7'h4D; pb = pulses;
    tcyc(1'b0, 1'b0); tcyc(1'b1, 1'b0);
    low_bits(7'h4D, 7);
    tcyc(1'b1, 1'b0); tcyc(1'b1, 1'b0); tcyc(1'b0, 1'b0);
    repeat (6) @(negedge clk);
    chk("R2 single high code", 32'(frame_code), 32'(fc));
    chk("R2 single high pulse", 32'(pulses - pb), 32'd0);

    // R5: partial frame interrupted by TMS high is dropped
    trig_code = 7'h6B; pb = pulses;
    tcyc(1'b0, 1'b0); tcyc(1'b1, 1'b0); tcyc(1'b1, 1'b0);
    low_bits(7'h0B, 4);
    tcyc(1'b1, 1'b0);
    low_bits(7'h06, 3);
    tcyc(1'b1, 1'b0); tcyc(1'b1, 1'b0); tcyc(1'b0, 1'b0);
    repeat (6) @(negedge clk);
    chk("R5 abort code", 32'(frame_code), 32'(fc));
    chk("R5 abort pulse", 32'(pulses - pb), 32'd0);

    // R8: 14 low bits form only one frame
    trig_code = 7'h6A; pb = pulses;
    tcyc(1'b0, 1'b0); tcyc(1'b1, 1'b0); tcyc(1'b1, 1'b0);
    low_bits(7'h15, 7);
    low_bits(7'h6A, 7);
    tcyc(1'b1, 1'b0); tcyc(1'b1, 1'b0); tcyc(1'b0, 1'b0);
    repeat (6) @(negedge clk);
    chk("R8 no second frame code", 32'(frame_code), 32'h15);
    chk("R8 no second frame pulse", 32'(pulses - pb), 32'd0);

    // R3 / R4 / R6: random loads
    for (int n = 0; n < 40; n++) begin
      logic [5:0] ir;
      logic a, b;
      logic [6:0] e;
      int hs;
      ir = 6'($urandom); a = 1'($urandom); b = 1'($urandom);
      hs = 2 + int'($urandom % 3);
      e = exp_frame(ir, a, b);
      trig_code = ($urandom % 2 == 0) ? e : 7'($urandom);
      pb = pulses;
      scan_ir(ir, a, b, hs);
      chk("R3 random frame", 32'(frame_code), 32'(e));
      chk("R6 random pulse", 32'(pulses - pb), (trig_code == e) ? 32'd1 : 32'd0);
    end

    chk("R6 pulse width", 32'(wide), 32'd0);
    chk("R9 pulse latency", 32'(badlat), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule